// File: doc/BRIEF.md
# Coprocessor Segment Address Translator

This block sits between a 16-bit big-endian coprocessor and a little-endian host memory bus. Every coprocessor program or data access carries a 20-bit byte address. The block cuts that address into a 16-entry segment index and a 4-entry quarter-segment index. It looks up a 16 KB host page number in one of two fixed page tables: one for program fetches and one for data accesses. It then issues the access on the host bus. A page value of 255 means no host page exists. Such an access finishes at once without touching the host: a read returns zero and a write is discarded.

Host pages 40 to 47 hold a video framebuffer. For these pages the block reorders the low address bits so that the framebuffer appears linear to the coprocessor. All data words and byte enables are byte-swapped in both directions, because the two buses use opposite byte orders.

After reset a memory-enable flag is clear. While it is clear, program reads are served from a local boot ROM instead of host memory. A write to the serial-control register loads the flag from bit 5 of the written byte, and halting the coprocessor clears it. A small window of coprocessor I/O space is passed through to host I/O with the same byte swapping.

Coprocessor requests use a valid/ready handshake, and each accepted request returns exactly one single-cycle response pulse.

Top module: `cop_seg_xlate`

## Requirements
- R1: After reset, `cp_req_ready` is 1 and `cp_rsp_valid`, `host_valid` and `rom_en` are 0. The memory-enable flag is clear.
- R2: For program accesses (`cp_req_space` = 0), the table row is address bits 19:16 and the column is bits 15:14. The host address is the page shifted left by 14, OR address bits 13:0. Some program-table entries are: row 0 gives pages 0,1,2,3; row 8 gives 1,2,8,9; rows 12 to 15 give pages 16 to 31 in order.
- R3: Data accesses (`cp_req_space` = 1) use a separate table. For example, data row 1 gives pages 4,5,6,7 where program row 1 gives 1,2,3,255, and data row 8 column 3 gives page 11.
- R4: A page value of 255 never reaches the host. Examples are program rows 4 and 7, program row 1 column 3, and data row 7. A read returns 0 and a write is dropped. The response arrives in the cycle right after the accepting clock edge.
- R5: For host pages 40 to 47 (program row 3 gives 46,40,41,42), the formed address bits are rearranged as follows. Bits 7 and 6 move up to 14 and 13. Bits 14 to 8 shift down to 12 to 6. Bit 15, bits 5:0 and bits 19:16 stay where they are. All other pages are not permuted.
- R6: Host write data is the coprocessor data with its two bytes exchanged, and the byte-enable bits are exchanged the same way. Read data from the host is byte-swapped before it is returned.
- R7: While the flag is clear, a program read drives `rom_en` high for one cycle with `rom_addr` = address bits 13:1. The synchronous ROM word is returned unswapped two cycles after the accepting edge. Program writes and data accesses still go to the host.
- R8: A `mode_wr` pulse loads the flag from bit 5 of `mode_wdata`. `cop_halt` clears the flag and takes priority over a write in the same cycle.
- R9: I/O accesses (`cp_req_space` = 2) to 0x8000 to 0x83FF go to the host with `host_io` = 1, host address = coprocessor address minus 0x8000, and byte swapping. I/O accesses outside that window, and space 3, behave as unmapped.
- R10: `host_valid` and its fields hold steady until `host_ready` is seen. The response follows in the cycle after that edge. `cp_req_ready` stays low from acceptance until the response, and the response lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cp_req_valid | input | 1 | Coprocessor request valid |
| cp_req_ready | output | 1 | Block can accept a request |
| cp_req_space | input | 2 | 0 program, 1 data, 2 I/O |
| cp_req_write | input | 1 | 1 write, 0 read |
| cp_req_addr | input | ADDR_W | Coprocessor byte address |
| cp_req_wdata | input | DATA_W | Write data, big-endian |
| cp_req_be | input | DATA_W/8 | Byte enables, big-endian lanes |
| cp_rsp_valid | output | 1 | One-cycle response pulse |
| cp_rsp_rdata | output | DATA_W | Read data (0 for writes and unmapped) |
| mode_wr | input | 1 | Serial-control register write strobe |
| mode_wdata | input | 8 | Serial-control write byte |
| cop_halt | input | 1 | Coprocessor halted |
| host_valid | output | 1 | Host request valid |
| host_ready | input | 1 | Host completes the request |
| host_io | output | 1 | Host I/O space select |
| host_write | output | 1 | Host write |
| host_addr | output | ADDR_W | Host byte address |
| host_wdata | output | DATA_W | Host write data, little-endian |
| host_be | output | DATA_W/8 | Host byte enables |
| host_rdata | input | DATA_W | Host read data |
| rom_en | output | 1 | Boot ROM read strobe |
| rom_addr | output | ROM_AW | Boot ROM word address |
| rom_rdata | input | DATA_W | Boot ROM word, valid the cycle after `rom_en` |

## Verification
Each result is due at a fixed cycle after the accepting edge:
- an unmapped or dropped access responds in the cycle right after that edge;
- a ROM read responds two cycles after it;
- a host access responds one cycle after the edge where `host_ready` is seen, so with a host delay of d cycles the response comes d+1 cycles after acceptance.

The driver records the number of the accepting edge together with the expected data and latency. The monitor, sampling on falling edges, compares both when the pulse appears. A host model compares each host request against its own expectation queue. It treats any host request it does not expect, such as a dropped write that leaks through, as a failure. It also confirms that `cp_req_ready` stays low while it delays `host_ready`.

// File: rtl/csx_pkg.sv
// Package for the segment address translator: request-space codes, the
// routing decision and the two fixed page tables.
// Assumes rows of 4 columns with an 8-bit page number, 255 meaning unmapped.
package csx_pkg;

    typedef enum logic [1:0] {
        SP_PROG = 2'd0,
        SP_DATA = 2'd1,
        SP_IO   = 2'd2,
        SP_NONE = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        RT_HOST = 2'd0,
        RT_ROM  = 2'd1,
        RT_DROP = 2'd2
    } route_e;

    localparam logic [7:0] PAGE_NONE = 8'hFF;
    localparam int         LIN_ROW   = 12;
    localparam int         LIN_BASE  = 16;

    // Program table row, packed as {col3, col2, col1, col0}
    function automatic logic [31:0] prog_row(input logic [3:0] r);
        logic [31:0] v;
        case (r)
            4'd0:    v = {8'd3,   8'd2,   8'd1,   8'd0};
            4'd1:    v = {8'd255, 8'd3,   8'd2,   8'd1};
            4'd2:    v = {8'd7,   8'd6,   8'd5,   8'd4};
            4'd3:    v = {8'd42,  8'd41,  8'd40,  8'd46};
            4'd4:    v = {8'd255, 8'd255, 8'd255, 8'd255};
            4'd5:    v = {8'd47,  8'd255, 8'd255, 8'd255};
            4'd6:    v = {8'd255, 8'd3,   8'd2,   8'd1};
            4'd7:    v = {8'd255, 8'd255, 8'd255, 8'd255};
            4'd8:    v = {8'd9,   8'd8,   8'd2,   8'd1};
            4'd9:    v = {8'd11,  8'd10,  8'd6,   8'd5};
            4'd10:   v = {8'd9,   8'd8,   8'd2,   8'd1};
            4'd11:   v = {8'd15,  8'd14,  8'd13,  8'd12};
            default: v = '0;
        endcase
        return v;
    endfunction

    // Data table row, packed as {col3, col2, col1, col0}
    function automatic logic [31:0] data_row(input logic [3:0] r);
        logic [31:0] v;
        case (r)
            4'd0:    v = {8'd3,   8'd2,   8'd1,   8'd0};
            4'd1:    v = {8'd7,   8'd6,   8'd5,   8'd4};
            4'd2:    v = {8'd7,   8'd6,   8'd5,   8'd4};
            4'd3:    v = {8'd42,  8'd41,  8'd40,  8'd46};
            4'd4:    v = {8'd255, 8'd255, 8'd255, 8'd255};
            4'd5:    v = {8'd47,  8'd3,   8'd2,   8'd1};
            4'd6:    v = {8'd255, 8'd3,   8'd2,   8'd1};
            4'd7:    v = {8'd255, 8'd255, 8'd255, 8'd255};
            4'd8:    v = {8'd11,  8'd10,  8'd6,   8'd5};
            4'd9:    v = {8'd11,  8'd10,  8'd6,   8'd5};
            4'd10:   v = {8'd9,   8'd8,   8'd2,   8'd1};
            4'd11:   v = {8'd15,  8'd14,  8'd13,  8'd12};
            default: v = '0;
        endcase
        return v;
    endfunction

    // Page lookup: the top four rows are a linear run computed, not listed
    function automatic logic [7:0] page_of(input logic is_data,
                                           input logic [3:0] r,
                                           input logic [1:0] c);
        logic [31:0] row;
        logic [7:0]  pg;
        row = is_data ? data_row(r) : prog_row(r);
        if (int'(r) >= LIN_ROW)
            pg = 8'(LIN_BASE + 4 * (int'(r) - LIN_ROW) + int'(c));
        else
            pg = row[8*c +: 8];
        return pg;
    endfunction

endpackage

// File: rtl/csx_lane_swap.sv
// Reverses the order of LANES chunks of CHUNK bits each.
// Used for data words (8-bit chunks) and byte enables (1-bit chunks).
// Pure wiring, no state.
module csx_lane_swap #(
    parameter int LANES = 2,
    parameter int CHUNK = 8
) (
    input  logic [LANES*CHUNK-1:0] din,
    output logic [LANES*CHUNK-1:0] dout
);
    // One assignment per lane, mirrored position
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[i*CHUNK +: CHUNK] = din[(LANES-1-i)*CHUNK +: CHUNK];
    end
endmodule

// File: rtl/csx_page_lookup.sv
// Combinational page translation for program or data space.
// It selects a row and column from the upper address bits and looks up the
// page, then forms the host address. For framebuffer pages it also permutes
// the low 16 bits.
// Assumes ADDR_W == PAGE_SHIFT + 6 (16 rows of 4 quarter segments).
module csx_page_lookup
    import csx_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 14,
    parameter int FB_FIRST   = 40,
    parameter int FB_LAST    = 47
) (
    input  logic              is_data,
    input  logic [ADDR_W-1:0] cop_addr,
    output logic              mapped,
    output logic [ADDR_W-1:0] phys_addr
);
    localparam int COL_LSB = PAGE_SHIFT;
    localparam int ROW_LSB = PAGE_SHIFT + 2;

    logic [3:0]        row;
    logic [1:0]        col;
    logic [7:0]        page;
    logic [ADDR_W-1:0] formed;
    logic              in_fb;

    // Table read and address formation
    always_comb begin
        row    = cop_addr[ROW_LSB +: 4];
        col    = cop_addr[COL_LSB +: 2];
        page   = page_of(is_data, row, col);
        mapped = (page != PAGE_NONE);
        formed = (ADDR_W'(page) << PAGE_SHIFT) | ADDR_W'(cop_addr[PAGE_SHIFT-1:0]);
        in_fb  = (int'(page) >= FB_FIRST) && (int'(page) <= FB_LAST);
    end

    // Framebuffer bit permutation: bits 7:6 go up to 14:13, bits 14:8 down to 12:6
    always_comb begin
        if (in_fb)
            phys_addr = {formed[ADDR_W-1:16], formed[15], formed[7:6],
                         formed[14:8], formed[5:0]};
        else
            phys_addr = formed;
    end
endmodule

// File: rtl/csx_boot_ctl.sv
// Memory-enable flag. While the flag is clear, program reads are served by
// the boot ROM. A serial-control write loads the flag from one bit of the
// written byte; a coprocessor halt clears it and wins over the write.
module csx_boot_ctl #(
    parameter int CFG_W  = 8,
    parameter int EN_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             halt,
    output logic             mem_en
);
    // Flag register: halt first, then register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            mem_en <= 1'b0;
        else if (halt)
            mem_en <= 1'b0;
        else if (cfg_wr)
            mem_en <= cfg_data[EN_BIT];
    end
endmodule

// File: rtl/cop_seg_xlate.sv
// Top of the segment address translator. It accepts one coprocessor request
// at a time, routes it at acceptance (host bus, boot ROM or drop) and returns
// a one-cycle response.
// Assumes a synchronous ROM (data valid the cycle after rom_en) and a host
// that may hold host_ready low for any number of cycles.
module cop_seg_xlate
    import csx_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int PAGE_SHIFT = 14,
    parameter int ROM_AW     = 13,
    parameter int IO_BASE    = 'h8000,
    parameter int IO_WIN_W   = 10,
    parameter int CFG_W      = 8,
    parameter int MEM_EN_BIT = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cp_req_valid,
    output logic                  cp_req_ready,
    input  logic [1:0]            cp_req_space,
    input  logic                  cp_req_write,
    input  logic [ADDR_W-1:0]     cp_req_addr,
    input  logic [DATA_W-1:0]     cp_req_wdata,
    input  logic [DATA_W/8-1:0]   cp_req_be,
    output logic                  cp_rsp_valid,
    output logic [DATA_W-1:0]     cp_rsp_rdata,
    input  logic                  mode_wr,
    input  logic [CFG_W-1:0]      mode_wdata,
    input  logic                  cop_halt,
    output logic                  host_valid,
    input  logic                  host_ready,
    output logic                  host_io,
    output logic                  host_write,
    output logic [ADDR_W-1:0]     host_addr,
    output logic [DATA_W-1:0]     host_wdata,
    output logic [DATA_W/8-1:0]   host_be,
    input  logic [DATA_W-1:0]     host_rdata,
    output logic                  rom_en,
    output logic [ROM_AW-1:0]     rom_addr,
    input  logic [DATA_W-1:0]     rom_rdata
);
    localparam int BE_W = DATA_W / 8;
    localparam logic [ADDR_W-IO_WIN_W-1:0] IO_TAG = (ADDR_W-IO_WIN_W)'(IO_BASE >> IO_WIN_W);

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_BUS  = 3'd1,
        ST_ROM  = 3'd2,
        ST_ROMW = 3'd3,
        ST_RESP = 3'd4
    } state_e;

    state_e            st;
    logic              mem_en;
    logic              lk_mapped;
    logic [ADDR_W-1:0] lk_addr;
    logic [DATA_W-1:0] wdata_sw;
    logic [BE_W-1:0]   be_sw;
    logic [DATA_W-1:0] rdata_sw;
    logic              accept;
    route_e            route;
    logic              route_io;
    logic [ADDR_W-1:0] route_addr;
    logic [DATA_W-1:0] rsp_data;

    csx_boot_ctl #(
        .CFG_W  (CFG_W),
        .EN_BIT (MEM_EN_BIT)
    ) i_boot (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (mode_wr),
        .cfg_data (mode_wdata),
        .halt     (cop_halt),
        .mem_en   (mem_en)
    );

    csx_page_lookup #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) i_lookup (
        .is_data   (cp_req_space == SP_DATA),
        .cop_addr  (cp_req_addr),
        .mapped    (lk_mapped),
        .phys_addr (lk_addr)
    );

    csx_lane_swap #(.LANES(BE_W), .CHUNK(8)) i_swap_wd (.din(cp_req_wdata), .dout(wdata_sw));
    csx_lane_swap #(.LANES(BE_W), .CHUNK(1)) i_swap_be (.din(cp_req_be),    .dout(be_sw));
    csx_lane_swap #(.LANES(BE_W), .CHUNK(8)) i_swap_rd (.din(host_rdata),   .dout(rdata_sw));

    assign cp_req_ready = (st == ST_IDLE);
    assign accept       = cp_req_valid && cp_req_ready;
    assign host_valid   = (st == ST_BUS);
    assign rom_en       = (st == ST_ROM);
    assign cp_rsp_valid = (st == ST_RESP);
    assign cp_rsp_rdata = rsp_data;

    // Routing decision for the request now on the inputs
    always_comb begin
        route      = RT_DROP;
        route_io   = 1'b0;
        route_addr = lk_addr;
        case (space_e'(cp_req_space))
            SP_IO: begin
                route_io   = 1'b1;
                route_addr = ADDR_W'(cp_req_addr[IO_WIN_W-1:0]);
                if (cp_req_addr[ADDR_W-1:IO_WIN_W] == IO_TAG)
                    route = RT_HOST;
            end
            SP_PROG: begin
                if (!cp_req_write && !mem_en)
                    route = RT_ROM;
                else if (lk_mapped)
                    route = RT_HOST;
            end
            SP_DATA: begin
                if (lk_mapped)
                    route = RT_HOST;
            end
            default: route = RT_DROP;
        endcase
    end

    // Sequencer: accept, wait for host or ROM, then one response cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    case (route)
                        RT_HOST: st <= ST_BUS;
                        RT_ROM:  st <= ST_ROM;
                        default: st <= ST_RESP;
                    endcase
                end
                ST_BUS:  if (host_ready) st <= ST_RESP;
                ST_ROM:  st <= ST_ROMW;
                ST_ROMW: st <= ST_RESP;
                ST_RESP: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Request fields captured at acceptance, held while the host is busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_io    <= 1'b0;
            host_write <= 1'b0;
            host_addr  <= '0;
            host_wdata <= '0;
            host_be    <= '0;
            rom_addr   <= '0;
        end else if (accept) begin
            host_io    <= route_io;
            host_write <= cp_req_write;
            host_addr  <= route_addr;
            host_wdata <= wdata_sw;
            host_be    <= be_sw;
            rom_addr   <= cp_req_addr[ROM_AW:1];
        end
    end

    // Response data: zero for drops and writes, swapped host word, raw ROM word
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_data <= '0;
        else if (accept)
            rsp_data <= '0;
        else if (st == ST_BUS && host_ready)
            rsp_data <= host_write ? '0 : rdata_sw;
        else if (st == ST_ROMW)
            rsp_data <= rom_rdata;
    end
endmodule

// File: rtl/csx_checker.sv
// Protocol checker for the segment address translator, bound to the top.
module csx_checker #(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 16,
    parameter int IO_WIN_W = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cp_req_ready,
    input logic                cp_rsp_valid,
    input logic                host_valid,
    input logic                host_ready,
    input logic                host_io,
    input logic                host_write,
    input logic [ADDR_W-1:0]   host_addr,
    input logic [DATA_W-1:0]   host_wdata,
    input logic [DATA_W/8-1:0] host_be,
    input logic                rom_en,
    input logic                cop_halt,
    input logic                mem_en
);
    // R10
    host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && !host_ready |=> host_valid && $stable(host_addr) &&
        $stable(host_wdata) && $stable(host_be) && $stable(host_write) && $stable(host_io));

    // R10
    host_done_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && host_ready |=> cp_rsp_valid);

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_rsp_valid |=> !cp_rsp_valid && cp_req_ready);

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid || rom_en |-> !cp_req_ready);

    // R7
    rom_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_en |=> !rom_en && !host_valid && !cp_rsp_valid);

    // R8
    halt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_halt |=> !mem_en);

    // R9
    io_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && host_io |-> host_addr[ADDR_W-1:IO_WIN_W] == '0);
endmodule

bind cop_seg_xlate csx_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IO_WIN_W (IO_WIN_W)
) i_csx_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cp_req_ready (cp_req_ready),
    .cp_rsp_valid (cp_rsp_valid),
    .host_valid   (host_valid),
    .host_ready   (host_ready),
    .host_io      (host_io),
    .host_write   (host_write),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .host_be      (host_be),
    .rom_en       (rom_en),
    .cop_halt     (cop_halt),
    .mem_en       (mem_en)
);

// File: tb/test_cop_seg_xlate.sv
// Scoreboard bench: the driver queues expected host requests and responses,
// a host model and a response monitor pop and compare them.
module test_cop_seg_xlate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_req_valid = 1'b0;
    logic        cp_req_ready;
    logic [1:0]  cp_req_space = 2'd0;
    logic        cp_req_write = 1'b0;
    logic [19:0] cp_req_addr = '0;
    logic [15:0] cp_req_wdata = '0;
    logic [1:0]  cp_req_be = 2'b11;
    logic        cp_rsp_valid;
    logic [15:0] cp_rsp_rdata;
    logic        mode_wr = 1'b0;
    logic [7:0]  mode_wdata = '0;
    logic        cop_halt = 1'b0;
    logic        host_valid;
    logic        host_ready = 1'b0;
    logic        host_io;
    logic        host_write;
    logic [19:0] host_addr;
    logic [15:0] host_wdata;
    logic [1:0]  host_be;
    logic [15:0] host_rdata = '0;
    logic        rom_en;
    logic [12:0] rom_addr;
    logic [15:0] rom_rdata = '0;

    cop_seg_xlate i_cop_seg_xlate (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic        io;
        logic        wr;
        logic [19:0] addr;
        logic [15:0] wdata;
        logic [1:0]  be;
        string       tag;
    } host_exp_t;

    typedef struct {
        logic        is_rd;
        logic [15:0] data;
        int          lat;
        string       tag;
    } rsp_exp_t;

    host_exp_t hq[$];
    rsp_exp_t  rq[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int acc_cyc = 0;
    int n_rsp = 0;
    int host_dly = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Synchronous boot ROM model
    always @(posedge clk) if (rom_en) rom_rdata <= {3'b101, rom_addr};

    function automatic logic [15:0] sw16(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    function automatic logic [15:0] host_word(input logic [19:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Host model: compares each request with its expectation and answers after host_dly cycles
    initial begin
        forever begin
            @(negedge clk);
            if (host_valid) begin
                if (hq.size() == 0) begin
                    check(0, "R4", "unexpected host access", host_addr, 0);
                end else begin
                    host_exp_t e;
                    e = hq.pop_front();
                    check(host_io == e.io && host_write == e.wr && host_addr == e.addr,
                          e.tag, "host io/write/addr", {host_io, host_write, 10'd0, host_addr},
                          {e.io, e.wr, 10'd0, e.addr});
                    if (e.wr)
                        check(host_wdata == e.wdata && host_be == e.be, e.tag,
                              "host wdata/be (R6)", {14'd0, host_be, host_wdata}, {14'd0, e.be, e.wdata});
                end
                for (int k = 0; k < host_dly; k++) begin
                    @(negedge clk);
                    if (k == 0) check(!cp_req_ready && host_valid, "R10", "busy while host waits",
                                      {cp_req_ready, host_valid}, 2'b01);
                end
                host_ready = 1'b1;
                host_rdata = host_word(host_addr);
                @(negedge clk);
                host_ready = 1'b0;
            end
        end
    end

    // Response monitor: data and latency against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (cp_rsp_valid) begin
                if (rq.size() == 0) begin
                    check(0, "R10", "unexpected response", cp_rsp_rdata, 0);
                end else begin
                    rsp_exp_t e;
                    e = rq.pop_front();
                    check(cyc - acc_cyc == e.lat, e.tag, "response latency", cyc - acc_cyc, e.lat);
                    if (e.is_rd)
                        check(cp_rsp_rdata == e.data, e.tag, "read data", cp_rsp_rdata, e.data);
                end
                n_rsp++;
            end
        end
    end

    // Driver: one request, with its expected host request and response
    task automatic access(input logic [1:0] sp, input logic wr, input logic [19:0] a,
                          input logic [15:0] wd, input logic [1:0] be,
                          input bit to_host, input bit to_rom, input logic [19:0] haddr,
                          input int dly, input logic [15:0] exp_rd, input string tag);
        rsp_exp_t  r;
        host_exp_t h;
        int target;
        if (to_host) begin
            h.io = (sp == 2'd2); h.wr = wr; h.addr = haddr;
            h.wdata = sw16(wd); h.be = {be[0], be[1]}; h.tag = tag;
            hq.push_back(h);
        end
        host_dly = dly;
        r.is_rd = !wr;
        r.data  = exp_rd;
        r.lat   = to_host ? 1 + dly : (to_rom ? 2 : 0);
        r.tag   = tag;
        rq.push_back(r);
        target = n_rsp + 1;
        @(negedge clk);
        check(cp_req_ready, "R10", "ready when idle", cp_req_ready, 1);
        cp_req_valid = 1'b1; cp_req_space = sp; cp_req_write = wr;
        cp_req_addr = a; cp_req_wdata = wd; cp_req_be = be;
        acc_cyc = cyc + 1;
        @(negedge clk);
        cp_req_valid = 1'b0;
        wait (n_rsp == target);
    endtask

    task automatic mode_write(input logic [7:0] v, input logic h);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = v; cop_halt = h;
        @(negedge clk);
        mode_wr = 1'b0; cop_halt = 1'b0;
    endtask

    task automatic halt_pulse();
        @(negedge clk);
        cop_halt = 1'b1;
        @(negedge clk);
        cop_halt = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cp_req_ready == 1'b1, "R1", "ready after reset", cp_req_ready, 1);
        check(cp_rsp_valid == 1'b0, "R1", "rsp_valid after reset", cp_rsp_valid, 0);
        check(host_valid == 1'b0, "R1", "host_valid after reset", host_valid, 0);
        check(rom_en == 1'b0, "R1", "rom_en after reset", rom_en, 0);

        // R7 boot mode: program read served by ROM, word 0x0009, unswapped
        access(2'd0, 0, 20'h40012, 16'h0, 2'b11, 0, 1, 20'h0, 0, 16'hA009, "R7");
        // R7/R6 program write still reaches host; bytes and enables swapped
        access(2'd0, 1, 20'h00104, 16'h1234, 2'b01, 1, 0, 20'h00104, 0, 16'h0, "R7");
        // R7/R3 data read reaches host in boot mode; data row 8 col 3 -> page 11
        access(2'd1, 0, 20'h8C0AA, 16'h0, 2'b11, 1, 0, 20'h2C0AA, 1, sw16(host_word(20'h2C0AA)), "R3");

        // R8 set flag via bit 5
        mode_write(8'h20, 1'b0);
        // R2 program row 0 col 1 -> page 1
        access(2'd0, 0, 20'h04006, 16'h0, 2'b11, 1, 0, 20'h04006, 0, sw16(host_word(20'h04006)), "R2");
        // R2/R6 program row 12 col 2 -> page 18, write both bytes
        access(2'd0, 1, 20'hC8100, 16'hBEEF, 2'b11, 1, 0, 20'h48100, 2, 16'h0, "R2");
        // R2 program row 15 col 3 -> page 31
        access(2'd0, 0, 20'hFC002, 16'h0, 2'b11, 1, 0, 20'h7C002, 0, sw16(host_word(20'h7C002)), "R2");
        // R2 program row 8 col 2 -> page 8
        access(2'd0, 0, 20'h88004, 16'h0, 2'b11, 1, 0, 20'h20004, 3, sw16(host_word(20'h20004)), "R2");
        // R3 same address, different tables: data -> page 4, program -> page 1
        access(2'd1, 0, 20'h10020, 16'h0, 2'b11, 1, 0, 20'h10020, 0, sw16(host_word(20'h10020)), "R3");
        access(2'd0, 0, 20'h10020, 16'h0, 2'b11, 1, 0, 20'h04020, 0, sw16(host_word(20'h04020)), "R3");

        // R4 unmapped: program row 4 read, program row 1 col 3 write, data row 7 read
        access(2'd0, 0, 20'h41234, 16'h0, 2'b11, 0, 0, 20'h0, 0, 16'h0000, "R4");
        access(2'd0, 1, 20'h1C000, 16'hDEAD, 2'b11, 0, 0, 20'h0, 0, 16'h0, "R4");
        access(2'd1, 0, 20'h7ABCE, 16'h0, 2'b11, 0, 0, 20'h0, 0, 16'h0000, "R4");

        // R5 framebuffer page 40: formed 0xA16C2 -> 0xA6582
        access(2'd0, 0, 20'h356C2, 16'h0, 2'b11, 1, 0, 20'hA6582, 0, sw16(host_word(20'hA6582)), "R5");
        // R5 page 42 write: formed 0xA80C0 -> 0xAE000, be 10 -> 01
        access(2'd0, 1, 20'h3C0C0, 16'h0102, 2'b10, 1, 0, 20'hAE000, 1, 16'h0, "R5");
        // R5 data page 46 keeps bit 15: 0xB8010 unchanged
        access(2'd1, 0, 20'h30010, 16'h0, 2'b11, 1, 0, 20'hB8010, 0, sw16(host_word(20'hB8010)), "R5");
        // R5 page 12 with bits 7:6 set is not permuted
        access(2'd0, 0, 20'hB00C0, 16'h0, 2'b11, 1, 0, 20'h300C0, 0, sw16(host_word(20'h300C0)), "R5");

        // R9 I/O window
        access(2'd2, 0, 20'h08122, 16'h0, 2'b11, 1, 0, 20'h00122, 0, sw16(host_word(20'h00122)), "R9");
        access(2'd2, 1, 20'h083FE, 16'hA1B2, 2'b01, 1, 0, 20'h003FE, 2, 16'h0, "R9");
        access(2'd2, 0, 20'h08400, 16'h0, 2'b11, 0, 0, 20'h0, 0, 16'h0000, "R9");
        access(2'd2, 0, 20'h07FFE, 16'h0, 2'b11, 0, 0, 20'h0, 0, 16'h0000, "R9");
        access(2'd3, 0, 20'h00100, 16'h0, 2'b11, 0, 0, 20'h0, 0, 16'h0000, "R9");

        // R8 halt clears the flag: program read goes to ROM again (word 0x080)
        halt_pulse();
        access(2'd0, 0, 20'hC8100, 16'h0, 2'b11, 0, 1, 20'h0, 0, 16'hA080, "R8");
        // R8 halt wins over a simultaneous write
        mode_write(8'h20, 1'b1);
        access(2'd0, 0, 20'h00006, 16'h0, 2'b11, 0, 1, 20'h0, 0, 16'hA003, "R8");
        // R8 set, then a write with bit 5 clear clears it
        mode_write(8'h20, 1'b0);
        access(2'd0, 0, 20'h00006, 16'h0, 2'b11, 1, 0, 20'h00006, 0, sw16(host_word(20'h00006)), "R8");
        mode_write(8'hDF, 1'b0);
        access(2'd0, 0, 20'h0000A, 16'h0, 2'b11, 0, 1, 20'h0, 0, 16'hA005, "R8");

        repeat (3) @(negedge clk);
        check(hq.size() == 0 && rq.size() == 0, "R10", "queues drained",
              hq.size() + rq.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule